// File: doc/BRIEF.md
# Eight-Line Interrupt Controller Register Interface

This block is the register file and command decoder of an eight-line interrupt controller. Software reaches it through two byte-wide ports. The command port starts the setup sequence, selects what a command read returns, and issues end-of-interrupt commands. The data port carries the setup words and, outside setup, the interrupt mask. The block holds the mask, the in-service bits, the vector base, the cascade map and the auto end-of-interrupt flag. It drives all of them out so that an interrupt dispatcher beside it can use them. The dispatcher marks lines as being serviced through a set vector.

The setup sequence starts with a command write that has bit 4 set. After that, one to three data writes follow, depending on two bits of that first word. Every access takes effect at the rising clock edge where its strobe is high. No access is ever stalled, so the block has no back-pressure and no handshake. Reads are combinational. A command read that follows a read-select command returns the in-service bits once, and every other command read returns zero, because the request register is never visible.

Top module: `irqc_regfile`

## Requirements
- R1: After reset, the mask, in-service bits, cascade map, vector base and auto-EOI flag are zero, setup is not in progress, and a command read returns 0x00.
- R2: A command write with bit 4 set starts (or restarts) setup. The next data write is taken as the vector base, with its bits 2:0 forced to zero.
- R3: The setup-start word selects single mode with bit 1 and asks for a fourth word with bit 0. With single mode and no fourth word, setup ends after the vector base. In cascade mode, the following data write loads the cascade map. A fourth word follows when bit 0 is set. `init_busy` is high exactly while setup words are still expected.
- R4: The fourth setup word sets the auto-EOI flag when its bit 1 is 1 and leaves the flag unchanged when bit 1 is 0. Its other bits have no effect. Setup ends after this word.
- R5: Outside setup, a data write loads the mask. A data read always returns the mask. Data writes during setup leave the mask unchanged.
- R6: A command write with bit 4 = 0 and bit 3 = 1 that equals 0x0B arms read-select. The next command read returns the in-service bits and disarms it. Any other such write leaves read-select unchanged. An unarmed command read returns 0x00.
- R7: A command write with bits 4 and 3 both 0 and bit 5 = 1 ends service. With bit 6 = 1, only the in-service bit numbered by bits 2:0 is cleared. With bit 6 = 0, all in-service bits are cleared. With bit 5 = 0, nothing changes.
- R8: Each 1 in `svc_set` sets that in-service bit. When an end of service and a set land in the same cycle, the clear is applied first and the set second.
- R9: When both write strobes are high in the same cycle, only the command write takes effect and the data write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_rd | input | 1 | Command port read strobe |
| dat_wr | input | 1 | Data port write strobe |
| dat_rd | input | 1 | Data port read strobe |
| wr_data | input | 8 | Write byte, shared by both ports |
| rd_data | output | 8 | Read byte (data read takes precedence) |
| svc_set | input | 8 | Dispatcher marks lines in service |
| vec_base | output | 8 | Vector base, low three bits zero |
| casc_map | output | 8 | Cascade map |
| isr_out | output | 8 | In-service bits |
| mask_out | output | 8 | Interrupt mask |
| auto_eoi | output | 1 | Auto end-of-interrupt flag |
| init_busy | output | 1 | Setup words still expected |

## Verification
The setup sequence is run with all four combinations of the single-mode and fourth-word bits. Each run shows whether the sequencer steers the second and third data writes to the right register and ends at the right step. A restart part-way through shows that a new start word discards the old progress. All 256 mask values are written and read back. Every command byte with the read-select marker is tried, so that only 0x0B arms the one-shot read.

End of service is swept over all eight levels against several in-service patterns. These sweeps separate the specific clear from the clear-all, and separate both from a command with no end-of-service bit. Colliding strobes show the ordering of a same-cycle set and clear, and the ordering of a same-cycle command write and data write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LINES   = 8;
  localparam int unsigned LVL_W   = $clog2(LINES);

  localparam int unsigned B_START  = 4;  // setup start marker
  localparam int unsigned B_SEL    = 3;  // read-select marker
  localparam int unsigned B_SINGLE = 1;  // single mode in start word
  localparam int unsigned B_NEED4  = 0;  // fourth word wanted
  localparam int unsigned B_EOI    = 5;  // end of service
  localparam int unsigned B_SPEC   = 6;  // specific level
  localparam int unsigned B_AEOI   = 1;  // auto-EOI in fourth word
  localparam logic [BYTE_W-1:0] RD_ISR_CODE = 8'h0B;
  localparam logic [BYTE_W-1:0] BASE_KEEP   = 8'hF8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_W2   = 2'd1,
    ST_W3   = 2'd2,
    ST_W4   = 2'd3
  } init_st_e;

  typedef struct packed {
    logic             start;
    logic             sel;
    logic             svc_cmd;
    logic             rd_isr;
    logic             eoi;
    logic             spec;
    logic             single;
    logic             need4;
    logic             aeoi;
    logic [LVL_W-1:0] lvl;
  } cmd_dec_t;
endpackage

// File: rtl/irqc_cmd_decode.sv
module irqc_cmd_decode
  import irqc_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_dec_t          dec_o
);
  always_comb begin
    dec_o.start   = byte_i[B_START];
    dec_o.sel     = !byte_i[B_START] && byte_i[B_SEL];
    dec_o.svc_cmd = !byte_i[B_START] && !byte_i[B_SEL];
    dec_o.rd_isr  = (byte_i == RD_ISR_CODE);
    dec_o.eoi     = byte_i[B_EOI];
    dec_o.spec    = byte_i[B_SPEC];
    dec_o.single  = byte_i[B_SINGLE];
    dec_o.need4   = byte_i[B_NEED4];
    dec_o.aeoi    = byte_i[B_AEOI];
    dec_o.lvl     = byte_i[LVL_W-1:0];
  end
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     single_i,
  input  logic     need4_i,
  input  logic     dwr_i,
  output init_st_e step_o,
  output logic     busy_o
);
  init_st_e st_q, st_d;
  logic     single_q, need4_q;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = ST_W2;
    end else if (dwr_i) begin
      unique case (st_q)
        ST_W2: begin
          if (!single_q)    st_d = ST_W3;
          else if (need4_q) st_d = ST_W4;
          else              st_d = ST_IDLE;
        end
        ST_W3:   st_d = need4_q ? ST_W4 : ST_IDLE;
        ST_W4:   st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_i) begin
        single_q <= single_i;
        need4_q  <= need4_i;
      end
    end
  end

  assign step_o = st_q;
  assign busy_o = (st_q != ST_IDLE);

  // R2
  start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (st_q == ST_W2));
  // R3
  last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_W4 && dwr_i && !start_i) |=> (st_q == ST_IDLE));
  // R3
  casc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_W2 && dwr_i && !start_i && !single_q) |=> (st_q == ST_W3));
endmodule

// File: rtl/irqc_isr_bank.sv
module irqc_isr_bank
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_i,
  input  logic             clr_one_i,
  input  logic             clr_all_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LINES-1:0] isr_o
);
  logic [LINES-1:0] isr_q;

  for (genvar g = 0; g < LINES; g++) begin : g_bit
    logic hit;
    assign hit = clr_all_i || (clr_one_i && (lvl_i == LVL_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        isr_q[g] <= 1'b0;
      else if (set_i[g]) isr_q[g] <= 1'b1;
      else if (hit)      isr_q[g] <= 1'b0;
    end
  end

  assign isr_o = isr_q;

  // R7
  spec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_one_i && !clr_all_i && !set_i[lvl_i]) |=> !isr_q[$past(lvl_i)]);
  // R7
  all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (isr_q == $past(set_i)));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((isr_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [7:0]        svc_set,
  output logic [7:0]        vec_base,
  output logic [7:0]        casc_map,
  output logic [7:0]        isr_out,
  output logic [7:0]        mask_out,
  output logic              auto_eoi,
  output logic              init_busy
);
  cmd_dec_t   dec;
  init_st_e   step;
  logic       busy;
  logic       dat_fire, start_w, sel_w, clr_one, clr_all;
  logic [BYTE_W-1:0] mask_q, base_q, casc_q;
  logic [LINES-1:0]  isr;
  logic       aeoi_q, rsel_q;

  irqc_cmd_decode u_dec (.byte_i(wr_data), .dec_o(dec));

  assign dat_fire = dat_wr && !cmd_wr;
  assign start_w  = cmd_wr && dec.start;
  assign sel_w    = cmd_wr && dec.sel;
  assign clr_one  = cmd_wr && dec.svc_cmd && dec.eoi && dec.spec;
  assign clr_all  = cmd_wr && dec.svc_cmd && dec.eoi && !dec.spec;

  irqc_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_w),
    .single_i(dec.single), .need4_i(dec.need4),
    .dwr_i(dat_fire), .step_o(step), .busy_o(busy)
  );

  irqc_isr_bank u_isr (
    .clk(clk), .rst_n(rst_n), .set_i(svc_set),
    .clr_one_i(clr_one), .clr_all_i(clr_all),
    .lvl_i(dec.lvl), .isr_o(isr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      casc_q <= '0;
      aeoi_q <= 1'b0;
    end else if (dat_fire) begin
      unique case (step)
        ST_IDLE: mask_q <= wr_data;
        ST_W2:   base_q <= wr_data & BASE_KEEP;
        ST_W3:   casc_q <= wr_data;
        ST_W4:   if (dec.aeoi) aeoi_q <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rsel_q <= 1'b0;
    else if (sel_w && dec.rd_isr)  rsel_q <= 1'b1;
    else if (cmd_rd)               rsel_q <= 1'b0;
  end

  always_comb begin
    if (dat_rd)               rd_data = mask_q;
    else if (cmd_rd && rsel_q) rd_data = isr;
    else                      rd_data = '0;
  end

  assign vec_base  = base_q;
  assign casc_map  = casc_q;
  assign isr_out   = isr;
  assign mask_out  = mask_q;
  assign auto_eoi  = aeoi_q;
  assign init_busy = busy;

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !cmd_wr && !init_busy) |=> (mask_out == $past(wr_data)));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |=> $stable(mask_out));
  // R9
  drop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && dat_wr) |=> $stable(mask_out));
  // R6
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !(cmd_wr && wr_data == RD_ISR_CODE)) |=> !rsel_q);
  // R4
  aeoi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_eoi |=> auto_eoi);
  // R2
  base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(vec_base) |-> $past(init_busy));
endmodule

// File: tb/irqc_regfile_test.sv
module irqc_regfile_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_rd = 0, dat_wr = 0, dat_rd = 0;
  logic [7:0] wr_data = 0, svc_set = 0;
  logic [7:0] rd_data, vec_base, casc_map, isr_out, mask_out;
  logic auto_eoi, init_busy;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irqc_regfile uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wr_data(wr_data), .rd_data(rd_data),
    .svc_set(svc_set), .vec_base(vec_base), .casc_map(casc_map),
    .isr_out(isr_out), .mask_out(mask_out), .auto_eoi(auto_eoi),
    .init_busy(init_busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask
  task automatic cmd_w(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1; wr_data = b;
    @(negedge clk); cmd_wr = 0;
  endtask
  task automatic dat_w(input logic [7:0] b);
    @(negedge clk); dat_wr = 1; wr_data = b;
    @(negedge clk); dat_wr = 0;
  endtask
  task automatic cmd_r(output logic [7:0] b);
    @(negedge clk); cmd_rd = 1; #1 b = rd_data;
    @(negedge clk); cmd_rd = 0;
  endtask
  task automatic dat_r(output logic [7:0] b);
    @(negedge clk); dat_rd = 1; #1 b = rd_data;
    @(negedge clk); dat_rd = 0;
  endtask
  task automatic mark(input logic [7:0] p);
    @(negedge clk); svc_set = p;
    @(negedge clk); svc_set = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    do_reset();
    // R1 reset state
    chk("R1 mask", mask_out, 8'h00);
    chk("R1 isr", isr_out, 8'h00);
    chk("R1 casc", casc_map, 8'h00);
    chk("R1 base", vec_base, 8'h00);
    chk("R1 aeoi", {7'd0, auto_eoi}, 8'h00);
    chk("R1 busy", {7'd0, init_busy}, 8'h00);
    cmd_r(r); chk("R1 cmd read", r, 8'h00);

    // R2 / R3 / R4 setup sweep over single and fourth-word bits
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic single, need4;
      logic [7:0] base, casc;
      single = cfg[1]; need4 = cfg[0];
      base = 8'h3F + 8'(cfg * 45);
      casc = 8'h81 ^ 8'(cfg * 17);
      do_reset();
      cmd_w(8'h10 | 8'(cfg));
      chk("R2 busy after start", {7'd0, init_busy}, 8'h01);
      dat_w(base);
      chk("R2 base", vec_base, base & 8'hF8);
      chk("R3 busy after base", {7'd0, init_busy}, {7'd0, !(single && !need4)});
      if (!single) begin
        dat_w(casc);
        chk("R3 casc", casc_map, casc);
        chk("R3 busy after casc", {7'd0, init_busy}, {7'd0, need4});
      end else begin
        chk("R3 casc untouched", casc_map, 8'h00);
      end
      if (need4) begin
        dat_w(8'hFD);
        chk("R4 aeoi bit clear", {7'd0, auto_eoi}, 8'h00);
        chk("R4 done", {7'd0, init_busy}, 8'h00);
      end
      dat_w(8'hC3);
      chk("R5 mask after setup", mask_out, 8'hC3);
    end

    // R4 sticky auto-EOI
    do_reset();
    cmd_w(8'h13); dat_w(8'h20); dat_w(8'h02);
    chk("R4 aeoi set", {7'd0, auto_eoi}, 8'h01);
    cmd_w(8'h13); dat_w(8'h20); dat_w(8'h00);
    chk("R4 aeoi kept", {7'd0, auto_eoi}, 8'h01);

    // R2 restart mid-setup
    do_reset();
    cmd_w(8'h11); dat_w(8'h10);
    cmd_w(8'h12); dat_w(8'h4F);
    chk("R2 restart base", vec_base, 8'h48);
    chk("R2 restart done", {7'd0, init_busy}, 8'h00);
    chk("R2 restart casc", casc_map, 8'h00);

    // R5 full mask sweep
    for (int v = 0; v < 256; v++) begin
      dat_w(8'(v)); dat_r(r);
      chk("R5 mask read", r, 8'(v));
    end
    dat_w(8'h5A); cmd_w(8'h11); dat_w(8'h77); dat_w(8'h33);
    chk("R5 mask held in setup", mask_out, 8'h5A);
    dat_w(8'h00);

    // R6 read-select sweep
    mark(8'hA5);
    for (int b = 0; b < 256; b++) begin
      if (b[4] == 1'b0 && b[3] == 1'b1) begin
        cmd_w(8'(b)); cmd_r(r);
        chk("R6 first read", r, (b == 8'h0B) ? 8'hA5 : 8'h00);
        cmd_r(r);
        chk("R6 second read", r, 8'h00);
      end
    end
    cmd_w(8'h0B); cmd_w(8'h0A); cmd_r(r);
    chk("R6 other code keeps arm", r, 8'hA5);

    // R7 end-of-service sweep
    for (int lvl = 0; lvl < 8; lvl++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'hFF : (p == 1) ? 8'h5A : 8'(1 << lvl);
        cmd_w(8'h20); mark(pat);
        cmd_w(8'h40 | 8'(lvl));
        chk("R7 no-eoi no change", isr_out, pat);
        cmd_w(8'h60 | 8'(lvl));
        chk("R7 specific", isr_out, pat & ~8'(1 << lvl));
      end
    end
    mark(8'hFF); cmd_w(8'h20);
    chk("R7 clear all", isr_out, 8'h00);

    // R8 same-cycle clear then set
    mark(8'hFF);
    @(negedge clk); cmd_wr = 1; wr_data = 8'h20; svc_set = 8'h04;
    @(negedge clk); cmd_wr = 0; svc_set = 0;
    chk("R8 set after clear", isr_out, 8'h04);
    @(negedge clk); cmd_wr = 1; wr_data = 8'h62; svc_set = 8'h04;
    @(negedge clk); cmd_wr = 0; svc_set = 0;
    chk("R8 set beats specific", isr_out, 8'h04);

    // R9 simultaneous writes
    dat_w(8'h11); mark(8'h30);
    @(negedge clk); cmd_wr = 1; dat_wr = 1; wr_data = 8'h20;
    @(negedge clk); cmd_wr = 0; dat_wr = 0;
    chk("R9 mask kept", mask_out, 8'h11);
    chk("R9 command applied", isr_out, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule